// File: doc/BRIEF.md
# Hardware Store Handshake Controller

This block sits beside a battery-backed or nonvolatile-shadowed SRAM and decides when a hardware-requested store into the nonvolatile copy begins. The request arrives on a wired-AND busy/request line that several memories share: any of them, or the system, may pull the line low. Each memory sees the same low level and decides on its own whether it has anything worth storing. The block reads the line through a synchronizer and pulls it down through an enable output, so that the line stays low for as long as any participant is busy.

When the line falls, the block first opens a grace window. Reads keep running and a write already under way may finish. New writes are refused from the moment the request is seen. When the window closes and the SRAM is idle, the block either starts a timed store (only if a write has landed since the last store or recall) or skips it. In both cases it then keeps the memory disabled until the line is seen high again. A recovery interval follows before access resumes. A software store command starts an unconditional store from idle. A recall completion clears the modified state.

Top module: `hw_store_arbiter`

## Requirements
- R1: After reset, line_pd, wr_inhibit, chip_dis, store_start and dirty are all 0.
- R2: A low line level asserts wr_inhibit SYNC_STAGES+1 clock edges after it is applied. A wr_req taken while wr_inhibit is 0 sets dirty. A wr_req while wr_inhibit is 1 leaves dirty unchanged.
- R3: During the grace window chip_dis stays 0. The window lasts DELAY_CYC cycles after wr_inhibit rises. It is extended for as long as sram_busy is 1, and ends on the first edge at which the delay has run out and sram_busy is 0.
- R4: If dirty is 1 when the grace window ends, line_pd is 1 for exactly STORE_CYC consecutive cycles starting in the cycle after that edge. chip_dis and wr_inhibit are 1 throughout.
- R5: If dirty is 0 when the grace window ends, no store starts: line_pd and store_start stay 0, and chip_dis rises in the cycle after that edge.
- R6: dirty is 0 once a store ends, and a recall_done pulse clears dirty.
- R7: After a store or a skipped store, chip_dis and wr_inhibit stay 1 while the line is low. Once the line is high, both fall SYNC_STAGES+1+RECOVER_CYC edges later. A low seen during recovery restarts the wait for a high line.
- R8: A sw_store pulse while idle starts a store on the next edge, whether or not dirty is set. A sw_store pulse while a store is running is ignored.
- R9: store_start is a single-cycle pulse in the first cycle of every store, and line_pd is never 1 outside a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared busy/request line (asynchronous, low = request/busy) |
| sram_busy | input | 1 | An SRAM read or write cycle is in progress |
| wr_req | input | 1 | Single-cycle pulse: an SRAM write is presented |
| sw_store | input | 1 | Single-cycle unconditional store command from another initiator |
| recall_done | input | 1 | Single-cycle pulse marking the end of a recall |
| line_pd | output | 1 | Pull-down enable for the shared line; high during a store |
| wr_inhibit | output | 1 | New SRAM writes are refused |
| chip_dis | output | 1 | All SRAM access is disabled |
| store_start | output | 1 | One-cycle strobe starting the nonvolatile program interval |
| dirty | output | 1 | A write has been accepted since the last store or recall |

## Verification
The bench builds the block with a two-stage synchronizer, an 8-cycle grace delay, a 12-cycle store interval and a 5-cycle recovery interval. These short windows let each store be counted from its first to its last line_pd cycle. They also let sram_busy be held past the nominal grace end and then released, and allow the line to be kept low well after a store or a skip to show the hold. Every latency is measured in edges from the cycle the bench pulls or releases the line, so an off-by-one in the synchronizer or in any counter reload shows up directly.

// File: rtl/hsa_pkg.sv
package hsa_pkg;

    typedef enum logic [2:0] {
        HS_IDLE    = 3'd0,
        HS_GRACE   = 3'd1,
        HS_STORE   = 3'd2,
        HS_HOLD    = 3'd3,
        HS_RECOVER = 3'd4
    } hs_state_e;

    typedef struct packed {
        logic pull_dn;
        logic wr_block;
        logic access_off;
    } hs_ctl_t;

    function automatic int unsigned max3(input int unsigned a,
                                         input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // bits needed to hold values 0 .. cycles-1
    function automatic int unsigned cnt_width(input int unsigned cycles);
        return (cycles < 2) ? 1 : $clog2(cycles);
    endfunction

    function automatic hs_ctl_t ctl_of(input hs_state_e s);
        hs_ctl_t c;
        c = '0;
        case (s)
            HS_GRACE:   c.wr_block = 1'b1;
            HS_STORE:   begin c.pull_dn = 1'b1; c.wr_block = 1'b1; c.access_off = 1'b1; end
            HS_HOLD,
            HS_RECOVER: begin c.wr_block = 1'b1; c.access_off = 1'b1; end
            default:    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hsa_sync.sv
module hsa_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= RST_VAL;
                else     chain[g] <= chain[g-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hsa_timer.sv
module hsa_timer #(
    parameter int unsigned TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // R3, R4, R7: every window shrinks by exactly one per cycle
    a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/hsa_dirty.sv
module hsa_dirty (
    input  logic clk,
    input  logic rst,
    input  logic wr_req,
    input  logic wr_block,
    input  logic clr,
    output logic dirty
);
    logic take_wr;

    assign take_wr = wr_req && !wr_block;

    always_ff @(posedge clk) begin
        if (rst)          dirty <= 1'b0;
        else if (clr)     dirty <= 1'b0;
        else if (take_wr) dirty <= 1'b1;
    end

    // R2: a refused write cannot mark the array modified
    a_r2_blocked_write: assert property (@(posedge clk) disable iff (rst)
        (wr_req && wr_block && !dirty) |=> !dirty);
    // R6: a clear always wins
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clr |=> !dirty);
endmodule

// File: rtl/hsa_fsm.sv
module hsa_fsm
    import hsa_pkg::*;
#(
    parameter int unsigned TW          = 8,
    parameter int unsigned DELAY_CYC   = 100,
    parameter int unsigned STORE_CYC   = 1000,
    parameter int unsigned RECOVER_CYC = 70
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          line_low,
    input  logic          sram_busy,
    input  logic          sw_store,
    input  logic          dirty,
    input  logic          tmr_done,
    output hs_state_e     state,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          store_go,
    output logic          store_end
);
    localparam logic [TW-1:0] DELAY_LD   = TW'(DELAY_CYC - 1);
    localparam logic [TW-1:0] STORE_LD   = TW'(STORE_CYC - 1);
    localparam logic [TW-1:0] RECOVER_LD = TW'(RECOVER_CYC - 1);

    hs_state_e nxt;

    always_comb begin
        nxt       = state;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        store_go  = 1'b0;
        store_end = 1'b0;
        case (state)
            HS_IDLE: begin
                if (line_low) begin
                    nxt      = HS_GRACE;
                    tmr_load = 1'b1;
                    tmr_val  = DELAY_LD;
                end else if (sw_store) begin
                    nxt      = HS_STORE;
                    tmr_load = 1'b1;
                    tmr_val  = STORE_LD;
                    store_go = 1'b1;
                end
            end
            HS_GRACE: begin
                if (tmr_done && !sram_busy) begin
                    if (dirty) begin
                        nxt      = HS_STORE;
                        tmr_load = 1'b1;
                        tmr_val  = STORE_LD;
                        store_go = 1'b1;
                    end else begin
                        nxt = HS_HOLD;
                    end
                end
            end
            HS_STORE: begin
                if (tmr_done) begin
                    nxt       = HS_HOLD;
                    store_end = 1'b1;
                end
            end
            HS_HOLD: begin
                if (!line_low) begin
                    nxt      = HS_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = RECOVER_LD;
                end
            end
            HS_RECOVER: begin
                if (line_low)      nxt = HS_HOLD;
                else if (tmr_done) nxt = HS_IDLE;
            end
            default: nxt = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= HS_IDLE;
        else     state <= nxt;
    end

    // R5: a clean device never enters a store from the grace window
    a_r5_clean_skips: assert property (@(posedge clk) disable iff (rst)
        (state == HS_GRACE && tmr_done && !sram_busy && !dirty) |=> (state == HS_HOLD));
    // R7: while the line stays low after a store, the device keeps waiting
    a_r7_hold_on_low: assert property (@(posedge clk) disable iff (rst)
        (state == HS_HOLD && line_low) |=> (state == HS_HOLD));
    // R8: a command arriving mid-store does not restart the interval
    a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state == HS_STORE && !tmr_done) |=> (state == HS_STORE && !tmr_load));
endmodule

// File: rtl/hw_store_arbiter.sv
module hw_store_arbiter
    import hsa_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DELAY_CYC   = 100,
    parameter int unsigned STORE_CYC   = 1000000,
    parameter int unsigned RECOVER_CYC = 70
) (
    input  logic clk,
    input  logic rst,
    input  logic line_in,
    input  logic sram_busy,
    input  logic wr_req,
    input  logic sw_store,
    input  logic recall_done,
    output logic line_pd,
    output logic wr_inhibit,
    output logic chip_dis,
    output logic store_start,
    output logic dirty
);
    localparam int unsigned MAX_WIN = max3(DELAY_CYC, STORE_CYC, RECOVER_CYC);
    localparam int unsigned TW      = cnt_width(MAX_WIN);

    logic          line_high;
    logic          line_low;
    hs_state_e     state;
    hs_ctl_t       ctl;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          store_go;
    logic          store_end;
    logic          start_q;

    hsa_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_in),
        .q   (line_high)
    );

    assign line_low = !line_high;

    hsa_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    hsa_fsm #(
        .TW          (TW),
        .DELAY_CYC   (DELAY_CYC),
        .STORE_CYC   (STORE_CYC),
        .RECOVER_CYC (RECOVER_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .line_low  (line_low),
        .sram_busy (sram_busy),
        .sw_store  (sw_store),
        .dirty     (dirty),
        .tmr_done  (tmr_done),
        .state     (state),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .store_go  (store_go),
        .store_end (store_end)
    );

    assign ctl = ctl_of(state);

    hsa_dirty u_dirty (
        .clk      (clk),
        .rst      (rst),
        .wr_req   (wr_req),
        .wr_block (ctl.wr_block),
        .clr      (store_end || recall_done),
        .dirty    (dirty)
    );

    always_ff @(posedge clk) begin
        if (rst) start_q <= 1'b0;
        else     start_q <= store_go;
    end

    assign line_pd     = ctl.pull_dn;
    assign wr_inhibit  = ctl.wr_block;
    assign chip_dis    = ctl.access_off;
    assign store_start = start_q;

    // R9: the strobe marks the first cycle of a pull-down interval only
    a_r9_start_first: assert property (@(posedge clk) disable iff (rst)
        store_start |-> (line_pd && !$past(line_pd)));
    // R4: a store always runs with the array locked out
    a_r4_store_locked: assert property (@(posedge clk) disable iff (rst)
        line_pd |-> (chip_dis && wr_inhibit));
    // R6: the modified flag is gone when the pull-down is released
    a_r6_clean_after: assert property (@(posedge clk) disable iff (rst)
        $fell(line_pd) |-> !dirty);
    // R3: access is never cut while an SRAM cycle was still running
    a_r3_busy_respected: assert property (@(posedge clk) disable iff (rst)
        ($rose(chip_dis) && !$past(sw_store)) |-> !$past(sram_busy));
    // R9: at most one start per pull-down interval
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
        store_start |=> !store_start);
endmodule

// File: tb/tb_hw_store_arbiter.sv
module tb_hw_store_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int DELAY      = 8;
    localparam int STORE      = 12;
    localparam int RECOVER    = 5;
    localparam int GRACE_END  = SYNC + 1 + DELAY;

    typedef struct packed {
        logic       wr_first;
        logic [7:0] busy_edge;
        logic       exp_store;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b1, 8'd0,            1'b1},
        '{1'b0, 8'd0,            1'b0},
        '{1'b1, 8'(GRACE_END+3), 1'b1},
        '{1'b0, 8'(GRACE_END+3), 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ext_pull = 1'b0;
    logic sram_busy = 1'b0;
    logic wr_req = 1'b0;
    logic sw_store = 1'b0;
    logic recall_done = 1'b0;
    logic line_pd, wr_inhibit, chip_dis, store_start, dirty;
    logic line_bus;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    assign line_bus = !(ext_pull || line_pd);

    always #(CLK_PERIOD/2) clk = ~clk;

    hw_store_arbiter #(
        .SYNC_STAGES (SYNC),
        .DELAY_CYC   (DELAY),
        .STORE_CYC   (STORE),
        .RECOVER_CYC (RECOVER)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .line_in     (line_bus),
        .sram_busy   (sram_busy),
        .wr_req      (wr_req),
        .sw_store    (sw_store),
        .recall_done (recall_done),
        .line_pd     (line_pd),
        .wr_inhibit  (wr_inhibit),
        .chip_dis    (chip_dis),
        .store_start (store_start),
        .dirty       (dirty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // release the line and measure the recovery (R7)
    task automatic release_line();
        int first_dis_low = 0;
        int first_inh_low = 0;
        ext_pull = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            step();
            if (!chip_dis && first_dis_low == 0) first_dis_low = k;
            if (!wr_inhibit && first_inh_low == 0) first_inh_low = k;
        end
        chk(first_dis_low == SYNC + 1 + RECOVER, "R7 chip_dis release", first_dis_low, SYNC + 1 + RECOVER);
        chk(first_inh_low == SYNC + 1 + RECOVER, "R7 wr_inhibit release", first_inh_low, SYNC + 1 + RECOVER);
    endtask

    task automatic run_hw(input vec_t v);
        int first_inh = 0, first_dis = 0, first_pd = 0;
        int pd_cnt = 0, st_cnt = 0, st_ok = 1;
        int exp_dis, lim;
        if (v.wr_first) begin
            wr_req = 1'b1;
            step();
            wr_req = 1'b0;
            chk(dirty == 1'b1, "R2 accepted write", int'(dirty), 1);
        end
        exp_dis = GRACE_END;
        if (v.busy_edge != 0 && int'(v.busy_edge) + 1 > exp_dis) exp_dis = int'(v.busy_edge) + 1;
        ext_pull  = 1'b1;
        sram_busy = (v.busy_edge != 0);
        lim = exp_dis + STORE + 6;
        for (int k = 1; k <= lim; k++) begin
            step();
            if (wr_inhibit && first_inh == 0) first_inh = k;
            if (chip_dis && first_dis == 0) first_dis = k;
            if (line_pd) begin
                if (first_pd == 0) first_pd = k;
                pd_cnt++;
            end
            if (store_start) begin
                st_cnt++;
                if (k != first_pd) st_ok = 0;
            end
            if (v.busy_edge != 0 && k == int'(v.busy_edge)) sram_busy = 1'b0;
        end
        chk(first_inh == SYNC + 1, "R2 inhibit latency", first_inh, SYNC + 1);
        chk(first_dis == exp_dis, "R3 grace length", first_dis, exp_dis);
        if (v.exp_store) begin
            chk(first_pd == exp_dis, "R4 store start point", first_pd, exp_dis);
            chk(pd_cnt == STORE, "R4 store length", pd_cnt, STORE);
            chk(st_cnt == 1 && st_ok == 1, "R9 start strobe", st_cnt, 1);
            chk(dirty == 1'b0, "R6 dirty after store", int'(dirty), 0);
        end else begin
            chk(pd_cnt == 0, "R5 no pull-down", pd_cnt, 0);
            chk(st_cnt == 0, "R5 no start strobe", st_cnt, 0);
        end
        chk(chip_dis == 1'b1 && wr_inhibit == 1'b1, "R7 held while low", int'(chip_dis), 1);
        release_line();
    endtask

    initial begin
        int pd_cnt, st_cnt, first_low;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk({line_pd, wr_inhibit, chip_dis, store_start, dirty} == 5'b0, "R1 reset outputs",
            int'({line_pd, wr_inhibit, chip_dis, store_start, dirty}), 0);

        // vector table walk: hardware requests
        foreach (VECS[i]) run_hw(VECS[i]);

        // R2: a write refused during the grace window leaves dirty clear
        ext_pull = 1'b1;
        repeat (SYNC + 2) step();
        chk(wr_inhibit == 1'b1, "R2 inhibit active", int'(wr_inhibit), 1);
        wr_req = 1'b1;
        step();
        wr_req = 1'b0;
        chk(dirty == 1'b0, "R2 blocked write", int'(dirty), 0);
        pd_cnt = 0;
        for (int k = 0; k < DELAY + STORE; k++) begin
            step();
            if (line_pd) pd_cnt++;
        end
        chk(pd_cnt == 0, "R5 blocked write causes no store", pd_cnt, 0);
        // R7: a brief high during recovery, then low again, keeps the device off
        ext_pull = 1'b0;
        repeat (SYNC + 2) step();
        ext_pull = 1'b1;
        repeat (RECOVER + SYNC + 4) step();
        chk(chip_dis == 1'b1, "R7 low during recovery re-holds", int'(chip_dis), 1);
        release_line();

        // R6: recall clears dirty, then a hardware request is skipped
        wr_req = 1'b1;
        step();
        wr_req = 1'b0;
        chk(dirty == 1'b1, "R6 dirty set before recall", int'(dirty), 1);
        recall_done = 1'b1;
        step();
        recall_done = 1'b0;
        chk(dirty == 1'b0, "R6 recall clears dirty", int'(dirty), 0);
        run_hw('{1'b0, 8'd0, 1'b0});

        // R8: software store with a clean array, second command ignored
        sw_store = 1'b1;
        step();
        sw_store = 1'b0;
        chk(store_start == 1'b1 && line_pd == 1'b1, "R8 software store starts", int'(store_start), 1);
        pd_cnt = 1;
        st_cnt = 1;
        for (int k = 1; k < STORE + 4; k++) begin
            sw_store = (k == 3);
            step();
            if (line_pd) pd_cnt++;
            if (store_start) st_cnt++;
            if (!line_pd) break;
        end
        sw_store = 1'b0;
        chk(pd_cnt == STORE, "R8 store length unaffected", pd_cnt, STORE);
        chk(st_cnt == 1, "R8 second command ignored", st_cnt, 1);
        // line released by the pull-down itself; measure recovery (R7)
        first_low = 0;
        for (int k = 1; k <= 40; k++) begin
            step();
            if (!chip_dis && first_low == 0) first_low = k;
        end
        chk(first_low == SYNC + 1 + RECOVER, "R7 recovery after software store", first_low, SYNC + 1 + RECOVER);
        chk(chip_dis == 1'b0 && line_pd == 1'b0, "R9 idle after recovery", int'(line_pd), 0);

        finish_run();
    end
endmodule